// File: doc/BRIEF.md
# Ternary Content-Addressable Memory with Serial Test Access

This block stores up to 512 ternary patterns of 18 positions each. Every position holds a one, a zero or a wildcard. A search compares an 18-bit key against every stored row in the same cycle. It returns three results: a per-row match vector, a hit flag and the index of the lowest-numbered matching row. Rows are written one at a time, and each position is supplied as a two-bit cell code. Writes and searches run only when their own strobe input is pulsed. A power-down input stops match evaluation, so no row can report a match while it is held.

For production test, the write and search operands can come from an internal serial shift register instead of the pins. All result bits can be captured into a second shift register and read out serially, so the array can be exercised through only a few pins.

Top module: `tcam_scan_top`

## Requirements
- R1: The code for key bit i sits at `wr_pat[2i+1:2i]`. Code 2'b10 stores a one, code 2'b01 stores a zero and code 2'b00 stores a wildcard, which takes no part in matching.
- R2: A synchronous reset (`rst` high at a clock edge) clears every row's valid flag, all result outputs, `wr_err` and both shift registers. A row that has not been written since reset never matches.
- R3: A valid row matches when every non-wildcard position equals the corresponding key bit. A valid row made only of wildcards matches every key.
- R4: Code 2'b11 is illegal. A write that contains it stores a wildcard in that position and sets `wr_err`. Every write strobe reloads `wr_err` (1 if any code was illegal, 0 otherwise), and `wr_err` holds between write strobes.
- R5: A search result appears on the outputs one clock edge after `srch_stb`. `match_vec[r]` is set for each matching row r, `hit` is the OR of all bits, and `hit_idx` is the lowest matching row, or 0 when there is no hit. The outputs hold until the next search strobe.
- R6: A search strobed while `pwr_dn` is high returns an all-zero vector, `hit` = 0 and `hit_idx` = 0.
- R7: `wr_stb` writes the pattern into row `wr_row` at the clock edge. A search strobed in the same cycle sees the array contents as they were before that write.
- R8: When `scan_en` is high and `scan_capture` is low, the 63-bit input register shifts left at each edge and takes `scan_in` into its lowest bit. Bits are sent MSB first, and the register word is {row[8:0], key[17:0], pattern[35:0]}. When `scan_mode` is 1, writes and searches use this word in place of the pins.
- R9: `scan_capture` loads the 523-bit output register with {hit, hit_idx[8:0], wr_err, match_vec[511:0]}, and capture takes priority over shifting. Each `scan_en` edge then shifts the register left, and `scan_out` always shows its MSB, so `hit` appears first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe |
| wr_row | input | 9 | Row address to write |
| wr_pat | input | 36 | Two-bit cell codes for the row |
| srch_stb | input | 1 | Search strobe |
| srch_key | input | 18 | Search key |
| pwr_dn | input | 1 | Blocks match evaluation |
| match_vec | output | 512 | Registered per-row match result |
| hit | output | 1 | At least one row matched |
| hit_idx | output | 9 | Lowest matching row |
| wr_err | output | 1 | Last write held an illegal code |
| scan_mode | input | 1 | Take operands from the input shift register |
| scan_en | input | 1 | Shift both registers |
| scan_capture | input | 1 | Parallel-load the output register |
| scan_in | input | 1 | Serial data into the input register |
| scan_out | output | 1 | MSB of the output register |

## Verification
The bench checks priority where several rows match: a wildcard-only row and an exact row that both hit must report the lower index. An encoder that scans in the wrong direction would return the higher row. It also checks the edge rows 0 and 511 while they are the only rows that hit, which a mis-sized index or address decode would break. An illegal 2'b11 write must both set the error flag and behave as a wildcard. A design that stored the code unchanged would then miss a key that differs only at that position. A search strobed together with a write must not see the new row. Power-down must blank the results. Reset must invalidate rows that were written earlier. Operands are also loaded serially, and the whole 523-bit result is read back serially. A wrong shift direction or a wrong field order in either register shows up as a corrupted row or key, or as a misplaced result bit.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int ROWS_DEF  = 512;
    localparam int KEY_W_DEF = 18;

    typedef enum logic [1:0] {
        CELL_DC   = 2'b00,
        CELL_ZERO = 2'b01,
        CELL_ONE  = 2'b10,
        CELL_BAD  = 2'b11
    } cell_e;

    // Does one stored cell accept this key bit?
    function automatic logic cell_agrees(input logic [1:0] code, input logic kbit);
        logic ok;
        case (code)
            CELL_DC:   ok = 1'b1;
            CELL_ZERO: ok = !kbit;
            CELL_ONE:  ok = kbit;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Illegal pair is replaced by a wildcard before storage
    function automatic logic [1:0] cell_clean(input logic [1:0] code);
        return (code == CELL_BAD) ? CELL_DC : code;
    endfunction

endpackage

// File: rtl/tcam_wr_filter.sv
module tcam_wr_filter
    import tcam_pkg::*;
#(
    parameter int  KEY_W = KEY_W_DEF,
    localparam int PAT_W = 2 * KEY_W
) (
    input  logic [PAT_W-1:0] raw_pat,
    output logic [PAT_W-1:0] clean_pat,
    output logic             bad_code
);

    logic [KEY_W-1:0] bad_bits;

    for (genvar b = 0; b < KEY_W; b++) begin : g_cell
        assign clean_pat[2*b+1:2*b] = cell_clean(raw_pat[2*b+1:2*b]);
        assign bad_bits[b]          = (raw_pat[2*b+1:2*b] == CELL_BAD);
    end

    assign bad_code = |bad_bits;

endmodule

// File: rtl/tcam_array.sv
module tcam_array
    import tcam_pkg::*;
#(
    parameter int  ROWS  = ROWS_DEF,
    parameter int  KEY_W = KEY_W_DEF,
    localparam int IDX_W = $clog2(ROWS),
    localparam int PAT_W = 2 * KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [PAT_W-1:0] wr_pat,
    input  logic             eval_en,
    input  logic [KEY_W-1:0] key,
    output logic [ROWS-1:0]  match
);

    logic [PAT_W-1:0] cells [ROWS];
    logic [ROWS-1:0]  valid;

    function automatic logic row_agrees(input logic [PAT_W-1:0] pat,
                                        input logic [KEY_W-1:0] k);
        logic ok;
        ok = 1'b1;
        for (int b = 0; b < KEY_W; b++) begin
            ok = ok & cell_agrees(pat[2*b +: 2], k[b]);
        end
        return ok;
    endfunction

    // Pattern storage carries no reset; the valid flags gate it
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row] <= wr_pat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_row] <= 1'b1;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign match[r] = eval_en && valid[r] && row_agrees(cells[r], key);
    end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int  ROWS  = 512,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Walk downward so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/tcam_scan_chains.sv
module tcam_scan_chains #(
    parameter int IN_W  = 63,
    parameter int OUT_W = 523
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             capture,
    input  logic             ser_in,
    input  logic [OUT_W-1:0] cap_data,
    output logic [IN_W-1:0]  in_word,
    output logic             ser_out
);

    logic [IN_W-1:0]  in_q;
    logic [OUT_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            if (capture) begin
                out_q <= cap_data;
            end else if (shift_en) begin
                out_q <= {out_q[OUT_W-2:0], 1'b0};
            end
            if (shift_en && !capture) begin
                in_q <= {in_q[IN_W-2:0], ser_in};
            end
        end
    end

    assign in_word = in_q;
    assign ser_out = out_q[OUT_W-1];

endmodule

// File: rtl/tcam_scan_top.sv
module tcam_scan_top
    import tcam_pkg::*;
#(
    parameter int  ROWS  = ROWS_DEF,
    parameter int  KEY_W = KEY_W_DEF,
    localparam int IDX_W = $clog2(ROWS),
    localparam int PAT_W = 2 * KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [PAT_W-1:0] wr_pat,
    input  logic             srch_stb,
    input  logic [KEY_W-1:0] srch_key,
    input  logic             pwr_dn,
    output logic [ROWS-1:0]  match_vec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             wr_err,
    input  logic             scan_mode,
    input  logic             scan_en,
    input  logic             scan_capture,
    input  logic             scan_in,
    output logic             scan_out
);

    typedef struct packed {
        logic [IDX_W-1:0] row;
        logic [KEY_W-1:0] key;
        logic [PAT_W-1:0] pat;
    } op_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             err;
        logic [ROWS-1:0]  vec;
    } res_t;

    localparam int OP_W  = $bits(op_t);
    localparam int RES_W = $bits(res_t);

    op_t              pin_op;
    op_t              chain_op;
    op_t              op;
    logic [OP_W-1:0]  chain_word;
    logic [PAT_W-1:0] clean_pat;
    logic             bad_code;
    logic [ROWS-1:0]  raw_match;
    logic             any_hit;
    logic [IDX_W-1:0] low_idx;
    res_t             res_q;

    assign pin_op   = {wr_row, srch_key, wr_pat};
    assign chain_op = chain_word;
    assign op       = scan_mode ? chain_op : pin_op;

    tcam_wr_filter #(.KEY_W(KEY_W)) u_filter (
        .raw_pat   (op.pat),
        .clean_pat (clean_pat),
        .bad_code  (bad_code)
    );

    tcam_array #(.ROWS(ROWS), .KEY_W(KEY_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_stb),
        .wr_row  (op.row),
        .wr_pat  (clean_pat),
        .eval_en (!pwr_dn),
        .key     (op.key),
        .match   (raw_match)
    );

    tcam_prio_enc #(.ROWS(ROWS)) u_enc (
        .req (raw_match),
        .any (any_hit),
        .idx (low_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            if (srch_stb) begin
                res_q.hit <= any_hit;
                res_q.idx <= low_idx;
                res_q.vec <= raw_match;
            end
            if (wr_stb) begin
                res_q.err <= bad_code;
            end
        end
    end

    tcam_scan_chains #(.IN_W(OP_W), .OUT_W(RES_W)) u_chains (
        .clk      (clk),
        .rst      (rst),
        .shift_en (scan_en),
        .capture  (scan_capture),
        .ser_in   (scan_in),
        .cap_data (res_q),
        .in_word  (chain_word),
        .ser_out  (scan_out)
    );

    assign match_vec = res_q.vec;
    assign hit       = res_q.hit;
    assign hit_idx   = res_q.idx;
    assign wr_err    = res_q.err;

endmodule

// File: rtl/tcam_scan_top_chk.sv
module tcam_scan_top_chk #(
    parameter int ROWS  = 512,
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_stb,
    input logic             srch_stb,
    input logic             pwr_dn,
    input logic [ROWS-1:0]  match_vec,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic             wr_err,
    input logic             scan_capture,
    input logic             scan_out
);

    localparam logic [ROWS-1:0] LSB_ONE = {{(ROWS-1){1'b0}}, 1'b1};

    // R2
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!hit && match_vec == '0 && hit_idx == '0 && !wr_err));

    // R6
    pwr_dn_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (srch_stb && pwr_dn) |=> (!hit && match_vec == '0));

    // R5
    idx_points_at_hit_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> match_vec[hit_idx]);

    // R5
    idx_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((match_vec & ((LSB_ONE << hit_idx) - LSB_ONE)) == '0));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !srch_stb |=> ($stable(match_vec) && $stable(hit) && $stable(hit_idx)));

    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(wr_err));

    // R9
    capture_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        scan_capture |=> (scan_out == $past(hit)));

endmodule

bind tcam_scan_top tcam_scan_top_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .srch_stb     (srch_stb),
    .pwr_dn       (pwr_dn),
    .match_vec    (match_vec),
    .hit          (hit),
    .hit_idx      (hit_idx),
    .wr_err       (wr_err),
    .scan_capture (scan_capture),
    .scan_out     (scan_out)
);

// File: tb/tcam_scan_top_test.sv
module tcam_scan_top_test;

    localparam int ROWS  = 512;
    localparam int KEY_W = 18;
    localparam int IDX_W = 9;
    localparam int PAT_W = 36;
    localparam int OP_W  = IDX_W + KEY_W + PAT_W;
    localparam int RES_W = 1 + IDX_W + 1 + ROWS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst          = 1'b1;
    logic             wr_stb       = 1'b0;
    logic [IDX_W-1:0] wr_row       = '0;
    logic [PAT_W-1:0] wr_pat       = '0;
    logic             srch_stb     = 1'b0;
    logic [KEY_W-1:0] srch_key     = '0;
    logic             pwr_dn       = 1'b0;
    logic             scan_mode    = 1'b0;
    logic             scan_en      = 1'b0;
    logic             scan_capture = 1'b0;
    logic             scan_in      = 1'b0;
    logic [ROWS-1:0]  match_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             wr_err;
    logic             scan_out;

    tcam_scan_top uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_row(wr_row), .wr_pat(wr_pat),
        .srch_stb(srch_stb), .srch_key(srch_key), .pwr_dn(pwr_dn),
        .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx), .wr_err(wr_err),
        .scan_mode(scan_mode), .scan_en(scan_en), .scan_capture(scan_capture),
        .scan_in(scan_in), .scan_out(scan_out)
    );

    typedef struct {
        logic [ROWS-1:0]  vec;
        logic             hit;
        logic [IDX_W-1:0] idx;
        string            tag;
    } exp_t;

    exp_t             sb [$];
    exp_t             last_e;
    logic [PAT_W-1:0] m_pat [ROWS];
    logic [ROWS-1:0]  m_valid = '0;
    logic             m_err   = 1'b0;
    int               checks  = 0;
    int               errors  = 0;

    task automatic check_val(string tag, string what,
                             logic [RES_W-1:0] act, logic [RES_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirement text
    function automatic logic [PAT_W-1:0] exact_pat(logic [KEY_W-1:0] k);
        logic [PAT_W-1:0] p;
        for (int b = 0; b < KEY_W; b++) p[2*b +: 2] = k[b] ? 2'b10 : 2'b01;
        return p;
    endfunction

    function automatic logic [PAT_W-1:0] m_clean(logic [PAT_W-1:0] p);
        logic [PAT_W-1:0] q;
        for (int b = 0; b < KEY_W; b++) q[2*b +: 2] = (p[2*b +: 2] == 2'b11) ? 2'b00 : p[2*b +: 2];
        return q;
    endfunction

    function automatic logic m_bad(logic [PAT_W-1:0] p);
        logic bad;
        bad = 1'b0;
        for (int b = 0; b < KEY_W; b++) if (p[2*b +: 2] == 2'b11) bad = 1'b1;
        return bad;
    endfunction

    function automatic logic m_row_hit(int r, logic [KEY_W-1:0] k);
        if (!m_valid[r]) return 1'b0;
        for (int b = 0; b < KEY_W; b++) begin
            if (m_pat[r][2*b +: 2] == 2'b10 && !k[b]) return 1'b0;
            if (m_pat[r][2*b +: 2] == 2'b01 &&  k[b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic exp_t m_search(logic [KEY_W-1:0] k, bit pd, string tag);
        exp_t e;
        e.vec = '0;
        e.idx = '0;
        e.tag = tag;
        if (!pd) for (int r = 0; r < ROWS; r++) e.vec[r] = m_row_hit(r, k);
        e.hit = |e.vec;
        for (int r = ROWS - 1; r >= 0; r--) if (e.vec[r]) e.idx = IDX_W'(r);
        return e;
    endfunction

    // Monitor: compares each registered search result with the scoreboard
    logic fired = 1'b0;
    always @(posedge clk) fired <= srch_stb && !rst;

    always @(negedge clk) begin : monitor
        exp_t e;
        if (fired) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected result: actual hit %0b expected none", hit);
            end else begin
                e = sb.pop_front();
                check_val(e.tag, "match_vec", match_vec, e.vec);
                check_val(e.tag, "hit", hit, e.hit);
                check_val(e.tag, "hit_idx", hit_idx, e.idx);
                last_e = e;
            end
        end
    end

    task automatic do_write(int row, logic [PAT_W-1:0] pat, string tag);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_row = IDX_W'(row);
        wr_pat = pat;
        @(negedge clk);
        wr_stb       = 1'b0;
        m_pat[row]   = m_clean(pat);
        m_valid[row] = 1'b1;
        m_err        = m_bad(pat);
        check_val(tag, "wr_err", wr_err, m_err);
    endtask

    task automatic do_search_k(logic [KEY_W-1:0] pin_key, logic [KEY_W-1:0] model_key,
                               bit pd, string tag);
        @(negedge clk);
        srch_stb = 1'b1;
        srch_key = pin_key;
        pwr_dn   = pd;
        sb.push_back(m_search(model_key, pd, tag));
        @(negedge clk);
        srch_stb = 1'b0;
        pwr_dn   = 1'b0;
    endtask

    task automatic do_search(logic [KEY_W-1:0] key, bit pd, string tag);
        do_search_k(key, key, pd, tag);
    endtask

    task automatic scan_load(logic [OP_W-1:0] w);
        for (int i = OP_W - 1; i >= 0; i--) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = w[i];
        end
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    task automatic scan_unload(output logic [RES_W-1:0] got);
        @(negedge clk);
        scan_capture = 1'b1;
        @(negedge clk);
        scan_capture = 1'b0;
        for (int i = RES_W - 1; i >= 0; i--) begin
            got[i]  = scan_out;
            scan_en = 1'b1;
            @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        logic [PAT_W-1:0] p;
        logic [KEY_W-1:0] k;
        logic [RES_W-1:0] got;
        int               r;

        repeat (3) @(negedge clk);
        // R2 R9 reset state
        check_val("R2", "hit", hit, 0);
        check_val("R2", "match_vec", match_vec, 0);
        check_val("R2", "hit_idx", hit_idx, 0);
        check_val("R4", "wr_err", wr_err, 0);
        check_val("R9", "scan_out", scan_out, 0);
        rst = 1'b0;

        do_search(18'h2A5A5, 0, "R2");

        // R1 exact row, edge rows alone in the array
        do_write(511, exact_pat(18'h00000), "R1");
        do_search(18'h00000, 0, "R5");
        do_write(5, exact_pat(18'h2A5A5), "R1");
        do_search(18'h2A5A5, 0, "R1");
        do_search(18'h2A5A4, 0, "R1");
        do_write(0, {2'b10, 34'h0}, "R1");
        do_search(18'h20000, 0, "R5");
        do_search(18'h2A5A5, 0, "R5");

        // R3 wildcard row matches any key
        do_write(10, '0, "R3");
        do_search(18'h3FFFF, 0, "R3");
        do_search(18'h15A5A, 0, "R3");

        // R4 illegal code stored as wildcard
        p = exact_pat(18'h12345);
        p[7:6] = 2'b11;
        do_write(20, p, "R4");
        do_search(18'h12345 ^ 18'h00008, 0, "R4");
        check_val("R4", "wr_err held", wr_err, 1);
        do_write(21, exact_pat(18'h00001), "R4");

        // R6 power-down blanks the result
        do_search(18'h2A5A5, 1, "R6");
        do_search(18'h2A5A5, 0, "R6");

        // R7 same-cycle write and search
        @(negedge clk);
        wr_stb   = 1'b1;
        wr_row   = 9'd30;
        wr_pat   = exact_pat(18'h0F0F0);
        srch_stb = 1'b1;
        srch_key = 18'h0F0F0;
        sb.push_back(m_search(18'h0F0F0, 0, "R7"));
        @(negedge clk);
        wr_stb      = 1'b0;
        srch_stb    = 1'b0;
        m_pat[30]   = exact_pat(18'h0F0F0);
        m_valid[30] = 1'b1;
        m_err       = 1'b0;
        do_search(18'h0F0F0, 0, "R7");

        // R3 R5 mixed traffic
        for (int n = 0; n < 60; n++) begin
            for (int b = 0; b < KEY_W; b++) begin
                r = int'($urandom % 8);
                p[2*b +: 2] = (r < 3) ? 2'b10 : (r < 6) ? 2'b01 : (r == 6) ? 2'b00 : 2'b11;
            end
            do_write(int'($urandom % ROWS), p, "R4");
        end
        for (int n = 0; n < 120; n++) begin
            r = int'($urandom % ROWS);
            k = KEY_W'($urandom);
            if (n % 2 == 0 && m_valid[r]) begin
                for (int b = 0; b < KEY_W; b++) begin
                    if (m_pat[r][2*b +: 2] == 2'b10) k[b] = 1'b1;
                    if (m_pat[r][2*b +: 2] == 2'b01) k[b] = 1'b0;
                end
            end
            do_search(k, (n % 9) == 4, (n % 9) == 4 ? "R6" : "R3");
        end

        // R8 operands through the input chain
        k = 18'h3C3C3;
        scan_load({9'd300, k, exact_pat(k)});
        scan_mode = 1'b1;
        @(negedge clk);
        wr_stb = 1'b1;
        wr_row = 9'd301;
        wr_pat = {PAT_W{1'b1}};
        @(negedge clk);
        wr_stb       = 1'b0;
        m_pat[300]   = exact_pat(k);
        m_valid[300] = 1'b1;
        m_err        = 1'b0;
        check_val("R8", "wr_err", wr_err, 0);
        do_search_k(~k, k, 0, "R8");
        scan_mode = 1'b0;
        do_search(~k, 0, "R8");
        do_search(k, 0, "R8");
        @(negedge clk);

        // R9 serial readout of all results
        scan_unload(got);
        check_val("R9", "scan image", got, {last_e.hit, last_e.idx, m_err, last_e.vec});

        // R2 reset invalidates written rows
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst     = 1'b0;
        m_valid = '0;
        m_err   = 1'b0;
        check_val("R2", "hit after reset", hit, 0);
        check_val("R2", "wr_err after reset", wr_err, 0);
        do_search(18'h2A5A5, 0, "R2");
        do_search(18'h3FFFF, 0, "R2");

        repeat (3) @(negedge clk);
        check_val("R5", "pending results", sb.size(), 0);
        finish_run();
    end

endmodule